// File: doc/BRIEF.md
# Dual-Clock FIFO with In-Band Programmable Almost Thresholds

This block is a 64-word by 18-bit first-in first-out buffer that links two unrelated clock domains. A producer pushes words on rising edges of the write clock while `wr_en` is high. A consumer pops words on rising edges of the read clock while `rd_en` is high. The oldest stored word is always presented on `rd_data` without a read request, so the first word pushed into an empty buffer is visible as soon as the empty flag clears. While `out_en_n` is high, `rd_data` is forced to zero and the buffer contents are untouched.

Four status outputs describe the fill level. `full_n` and `empty_n` are active low. `half_full` is active high. `almost_flag` goes high when the buffer is nearly empty or nearly full. The two almost margins are a lower margin L and an upper margin U, and each defaults to 8. They can be loaded in-band after reset. With `prog_en_n` low, the first write-clock edge copies `wr_data[4:0]` into both L and U. If `prog_en_n` is still low on the next edge, only U is reloaded. No word is stored on either programming edge.

Pointers cross between the domains as Gray codes through two-flop synchronizers. `full_n`, `half_full` and `almost_flag` are computed in the write domain. `empty_n` is computed in the read domain. The flags can therefore lag the true fill level by the synchronizer latency.

Top module: `dcfifo_prog`

## Requirements
- R1: Words leave on `rd_data` in exactly the order they were accepted, and the buffer holds up to 64 words of 18 bits.
- R2: A push while `full_n` is low and a pop while `empty_n` is low leave the stored words and both pointers unchanged.
- R3: After a clock edge with `rst_n` low, `full_n`=1, `empty_n`=0, `half_full`=0 and `almost_flag`=1.
- R4: Once traffic has settled, `full_n` is low exactly when 64 words are held.
- R5: Once traffic has settled, `half_full` is 1 when 32 or more words are held and 0 when 31 or fewer are held.
- R6: Once traffic has settled, `almost_flag` is 1 when the fill level is at most L or at least 64-U, and 0 otherwise. If `prog_en_n` stays high after reset, L = U = 8.
- R7: The window for programming opens at reset. It closes at the first stored word, or when `prog_en_n` is high on the edge that follows a programming edge. On the first write-clock edge in the window with `prog_en_n` low, `wr_data[4:0]` (0 to 31) is loaded into both L and U, and no word is stored on that edge.
- R8: On a second consecutive edge with `prog_en_n` low, only U is reloaded from `wr_data[4:0]` and no word is stored. Once the window is closed, `prog_en_n` has no effect: pushes proceed normally and L and U keep their values.
- R9: The first word pushed into an empty buffer drives `empty_n` high and appears on `rd_data` without any pop.
- R10: While `out_en_n` is high, `rd_data` is all zeros. Stored words and pointers are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (load) clock |
| rd_clk | input | 1 | Read (unload) clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en | input | 1 | Push request on the write clock |
| wr_data | input | 18 | Word to push; bits 4:0 also carry the margin value while programming |
| prog_en_n | input | 1 | Active-low enable for loading the almost margins |
| rd_en | input | 1 | Pop request on the read clock |
| out_en_n | input | 1 | Active-low output enable; when high, `rd_data` is zero |
| rd_data | output | 18 | Oldest stored word (first-word fall-through) |
| full_n | output | 1 | Low when 64 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High when 32 or more words are held |
| almost_flag | output | 1 | High when the fill level is within the lower or upper margin |

## Verification
The risky case is a push and a pop landing in the same period of their own clocks while the buffer is close to empty or close to full. In that case each side decides using a stale copy of the other side's pointer. The bench runs forked producer and consumer loops on clocks of unrelated periods, with push and pop rates skewed toward both the full and the empty extremes, so that such collisions occur often at the boundaries. Every popped word is compared with a queue model, and every flag is compared with the model's count after both sides have been idle longer than the synchronizer latency. The programming edge that coincides with a raised `wr_en` is judged by confirming that the empty flag stays low.

// File: rtl/dcfifo_pkg.sv
// Shared types for the dual-clock FIFO: margin width, default margin and
// the state of the in-band margin programming window.
package dcfifo_pkg;
    localparam int OFFSET_W = 5;
    typedef logic [OFFSET_W-1:0] offset_t;
    localparam offset_t OFFSET_DEFAULT = offset_t'(8);

    // PG_FIRST: nothing loaded yet; PG_SECOND: L and U loaded, U may be
    // reloaded; PG_CLOSED: margins frozen.
    typedef enum logic [1:0] {
        PG_FIRST  = 2'd0,
        PG_SECOND = 2'd1,
        PG_CLOSED = 2'd2
    } prog_state_e;
endpackage

// File: rtl/dcfifo_sync.sv
// Two-stage synchronizer for a Gray-coded pointer.
// Assumes that at most one bit of d changes per source clock cycle.
module dcfifo_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Pass the foreign pointer through two flops in the local domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
// Write-domain control: write pointer, full flag, half-full flag, almost
// flag and the in-band margin programming window.
// Assumes rgray_sync is the read pointer in Gray code, already synchronized.
// The fill level is the local write pointer minus the synchronized read
// pointer, so it can only overstate the true level.
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          prog_en_n,
    input  offset_t       prog_val,
    input  logic [AW:0]   rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          half_full,
    output logic          almost_flag
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2);

    logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s, level_d;
    logic          full_n_q, half_q, almost_q, rst_seen_q;
    prog_state_e   pst_q, pst_d;
    offset_t       lo_q, hi_q, lo_d, hi_d;
    logic          prog_win, prog_edge, push;

    // Convert the synchronized Gray read pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_sync >> i);
        end
    end

    assign prog_win  = (pst_q != PG_CLOSED);
    assign prog_edge = prog_win && !prog_en_n;
    assign push      = wr_en && full_n_q && !prog_edge;
    assign wbin_d    = wbin_q + {{(PW-1){1'b0}}, push};
    assign level_d   = wbin_d - rbin_s;

    // Next state of the programming window and of the two margins.
    always_comb begin
        pst_d = pst_q;
        lo_d  = lo_q;
        hi_d  = hi_q;
        case (pst_q)
            PG_FIRST: begin
                if (!prog_en_n) begin
                    lo_d  = prog_val;
                    hi_d  = prog_val;
                    pst_d = PG_SECOND;
                end else if (push) begin
                    pst_d = PG_CLOSED;
                end
            end
            PG_SECOND: begin
                if (!prog_en_n) begin
                    hi_d = prog_val;
                end
                pst_d = PG_CLOSED;
            end
            default: pst_d = PG_CLOSED;
        endcase
    end

    // Advance the pointer and register the write-domain flags.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin_q   <= '0;
            wgray_q  <= '0;
            full_n_q <= 1'b1;
            half_q   <= 1'b0;
            almost_q <= 1'b1;
            pst_q    <= PG_FIRST;
            lo_q     <= OFFSET_DEFAULT;
            hi_q     <= OFFSET_DEFAULT;
        end else begin
            wbin_q   <= wbin_d;
            wgray_q  <= wbin_d ^ (wbin_d >> 1);
            full_n_q <= (level_d != DEPTH_V);
            half_q   <= (level_d >= HALF_V);
            almost_q <= (level_d <= {{(PW-OFFSET_W){1'b0}}, lo_d}) ||
                        (level_d >= DEPTH_V - {{(PW-OFFSET_W){1'b0}}, hi_d});
            pst_q    <= pst_d;
            lo_q     <= lo_d;
            hi_q     <= hi_d;
        end
    end

    assign mem_we      = push;
    assign mem_addr    = wbin_q[AW-1:0];
    assign wgray       = wgray_q;
    assign full_n      = full_n_q;
    assign half_full   = half_q;
    assign almost_flag = almost_q;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge wr_clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            AST_RESET_WR_FLAGS: assert (full_n_q && !half_q && almost_q)
                else $error("write flags wrong after reset"); // R3
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n_q && wr_en) |=> $stable(wbin_q)); // R2
    AST_PROG_NO_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (prog_win && !prog_en_n) |=> $stable(wbin_q)); // R7
    AST_OFFSETS_FROZEN: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (pst_q == PG_CLOSED) |=> ($stable(lo_q) && $stable(hi_q))); // R8
    AST_COUNT_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ((wbin_q - rbin_s) <= DEPTH_V)); // R4
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
// Read-domain control: read pointer and empty flag.
// Assumes wgray_sync is the write pointer in Gray code, already synchronized.
// A word becomes visible only after its write pointer update has crossed.
module dcfifo_rd_ctrl #(
    parameter int AW = 6
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   rgray,
    output logic          empty_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
    logic          empty_n_q, pop, rst_seen_q;

    assign pop     = rd_en && empty_n_q;
    assign rbin_d  = rbin_q + {{(PW-1){1'b0}}, pop};
    assign rgray_d = rbin_d ^ (rbin_d >> 1);

    // Advance the read pointer and compare it with the write pointer.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin_q    <= '0;
            rgray_q   <= '0;
            empty_n_q <= 1'b0;
        end else begin
            rbin_q    <= rbin_d;
            rgray_q   <= rgray_d;
            empty_n_q <= (rgray_d != wgray_sync);
        end
    end

    assign mem_addr = rbin_q[AW-1:0];
    assign rgray    = rgray_q;
    assign empty_n  = empty_n_q;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge rd_clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            AST_RESET_EMPTY: assert (!empty_n_q)
                else $error("empty flag wrong after reset"); // R3
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n_q && rd_en) |=> $stable(rbin_q)); // R2
endmodule

// File: rtl/dcfifo_prog.sv
// Dual-clock FIFO top: storage array, pointer crossings and output gating.
// Assumes rst_n is held low for several edges of both clocks.
// rd_data shows the word at the read pointer (first-word fall-through).
module dcfifo_prog
    import dcfifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          prog_en_n,
    input  logic          rd_en,
    input  logic          out_en_n,
    output logic [DW-1:0] rd_data,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_full,
    output logic          almost_flag
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;

    dcfifo_wr_ctrl #(.AW(AW)) i_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .prog_en_n   (prog_en_n),
        .prog_val    (wr_data[OFFSET_W-1:0]),
        .rgray_sync  (rgray_ws),
        .mem_we      (we),
        .mem_addr    (waddr),
        .wgray       (wgray),
        .full_n      (full_n),
        .half_full   (half_full),
        .almost_flag (almost_flag)
    );

    dcfifo_rd_ctrl #(.AW(AW)) i_rd (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .wgray_sync (wgray_rs),
        .mem_addr   (raddr),
        .rgray      (rgray),
        .empty_n    (empty_n)
    );

    dcfifo_sync #(.W(PW)) i_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    dcfifo_sync #(.W(PW)) i_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    // Store an accepted word at the write pointer.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wr_data;
        end
    end

    // Present the oldest word, or zeros while the output is disabled.
    assign rd_data = out_en_n ? '0 : mem[raddr];
endmodule

// File: tb/test_dcfifo_prog.sv
module test_dcfifo_prog;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        rst_n = 1'b0, wr_en = 1'b0, prog_en_n = 1'b1;
    logic        rd_en = 1'b0, out_en_n = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        full_n, empty_n, half_full, almost_flag;

    int n_chk = 0, n_fail = 0;
    int m_lo = 8, m_hi = 8;
    logic [17:0] model [$];

    always #10 wr_clk = ~wr_clk;
    always #14.5 rd_clk = ~rd_clk;

    dcfifo_prog i_dcfifo_prog (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .prog_en_n(prog_en_n),
        .rd_en(rd_en), .out_en_n(out_en_n), .rd_data(rd_data),
        .full_n(full_n), .empty_n(empty_n), .half_full(half_full),
        .almost_flag(almost_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_almost(input int n);
        return ((n <= m_lo) || (n >= 64 - m_hi)) ? 1 : 0;
    endfunction

    task automatic settle_flags(input string where);
        repeat (10) @(negedge rd_clk);
        @(negedge wr_clk);
        chk({"R4 full_n ", where}, int'(full_n), (model.size() != 64) ? 1 : 0);
        chk({"R9 empty_n ", where}, int'(empty_n), (model.size() != 0) ? 1 : 0);
        chk({"R5 half_full ", where}, int'(half_full), (model.size() >= 32) ? 1 : 0);
        chk({"R6 almost_flag ", where}, int'(almost_flag), exp_almost(model.size()));
    endtask

    task automatic wr_run(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = ($urandom_range(99) < pct);
            wr_data = 18'($urandom);
            if (wr_en && full_n) model.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_run(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en = ($urandom_range(99) < pct);
            if (rd_en && empty_n) begin
                chk("R1 data order", int'(rd_data), int'(model[0]));
                void'(model.pop_front());
            end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; prog_en_n = 1'b1; out_en_n = 1'b0;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        model.delete();
        m_lo = 8; m_hi = 8;
        #1;
        chk("R3 full_n", int'(full_n), 1);
        chk("R3 empty_n", int'(empty_n), 0);
        chk("R3 half_full", int'(half_full), 0);
        chk("R3 almost_flag", int'(almost_flag), 1);
    endtask

    task automatic prog_edge(input logic [17:0] v);
        @(negedge wr_clk);
        prog_en_n = 1'b0; wr_en = 1'b1; wr_data = v;
    endtask

    initial begin
        repeat (200000) @(posedge wr_clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Default margins, directed fill through every boundary.
        do_reset();
        wr_run(1, 100);
        settle_flags("one word");
        chk("R9 fall-through data", int'(rd_data), int'(model[0]));
        @(negedge rd_clk); out_en_n = 1'b1; #1;
        chk("R10 gated data", int'(rd_data), 0);
        out_en_n = 1'b0; #1;
        chk("R10 data intact after gating", int'(rd_data), int'(model[0]));
        wr_run(7, 100);  settle_flags("8 words");
        wr_run(1, 100);  settle_flags("9 words");
        wr_run(22, 100); settle_flags("31 words");
        wr_run(1, 100);  settle_flags("32 words");
        wr_run(23, 100); settle_flags("55 words");
        wr_run(1, 100);  settle_flags("56 words");
        wr_run(8, 100);  settle_flags("64 words");
        wr_run(3, 100);  settle_flags("R2 writes while full");
        rd_run(64, 100); settle_flags("drained");
        rd_run(3, 100);  settle_flags("R2 reads while empty");
        wr_run(1, 100);  settle_flags("after empty reads");
        chk("R2 pointer kept on empty read", int'(rd_data), int'(model[0]));
        rd_run(1, 100);

        // One programming edge: L = U = 12, raised wr_en stores nothing.
        do_reset();
        prog_edge(18'h1540C);
        @(negedge wr_clk); prog_en_n = 1'b1; wr_en = 1'b0;
        m_lo = 12; m_hi = 12;
        settle_flags("R7 after single program edge");
        chk("R7 no word stored", int'(empty_n), 0);
        wr_run(12, 100); settle_flags("R7 level 12");
        wr_run(1, 100);  settle_flags("R7 level 13");
        wr_run(38, 100); settle_flags("R7 level 51");
        wr_run(1, 100);  settle_flags("R7 level 52");
        rd_run(52, 100);

        // Two programming edges: L = 3, U = 5, only bits 4:0 used.
        do_reset();
        prog_edge(18'h002A3);
        prog_edge(18'h3FFE5);
        @(negedge wr_clk); prog_en_n = 1'b1; wr_en = 1'b0;
        m_lo = 3; m_hi = 5;
        settle_flags("R8 after two program edges");
        wr_run(3, 100);  settle_flags("R8 level 3");
        wr_run(1, 100);  settle_flags("R8 level 4");
        wr_run(54, 100); settle_flags("R8 level 58");
        wr_run(1, 100);  settle_flags("R8 level 59");
        @(negedge wr_clk); prog_en_n = 1'b0;
        wr_run(1, 100);
        prog_en_n = 1'b1;
        settle_flags("R8 write with window closed");
        chk("R8 word stored after window", model.size(), 60);
        rd_run(56, 100); settle_flags("R8 level 4 again");
        rd_run(1, 100);  settle_flags("R8 level 3 again");
        rd_run(3, 100);  settle_flags("R8 drained");

        // Concurrent random traffic, skewed toward both extremes.
        do_reset();
        fork wr_run(400, 80); rd_run(300, 30); join
        settle_flags("R1 random fill bias");
        fork wr_run(300, 30); rd_run(400, 85); join
        settle_flags("R1 random drain bias");
        fork wr_run(500, 60); rd_run(400, 70); join
        settle_flags("R1 random balanced");
        rd_run(model.size(), 100);
        settle_flags("R1 final drain");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule